// File: doc/BRIEF.md
# Dual Trigger Input Capture

This block watches two asynchronous external trigger lines and reports them in a single 8-bit activity status word. For each line the word holds a live level bit and a sticky pending bit. The pending bit records that the line changed since software last cleared it. Software clears pending bits one at a time with a write-one-to-clear strobe.

A system time base that also stamps video frames drives `ts_i`. In raw mode software polls the status word. In buffered mode every cycle in which at least one synchronized level changes pushes one entry into a small first-word-fall-through event queue. The entry holds the status word as it stands after that change and the value of `ts_i` at that moment, so each trigger event can be matched to a frame. When the queue is full, a new event is dropped and a sticky overflow flag is raised.

Top module: `trig_capture`

## Requirements
- R1: After reset `status_o` is 0, `ev_valid_o` is 0 and `ovf_o` is 0.
- R2: `status_o` bit 1 is pending for trigger 0 and bit 2 is pending for trigger 1. Bit 5 is the level of trigger 0 and bit 6 is the level of trigger 1. Bits 0, 3, 4 and 7 are always 0.
- R3: Each trigger passes through a two-flop synchronizer and one edge-detect register. A level held on `trig_i` before rising edge k shows in the level bit and, if it differs from the previous level, sets the pending bit, both after edge k+2.
- R4: A pending bit is set by any level change, rising or falling. It stays set until a cycle with the matching `clr_pend_i` bit high clears it. When a change and a clear fall in the same cycle, the change wins and the bit stays set.
- R5: Level and pending bits update in the same way in raw mode (`buf_mode_i`=0) and in buffered mode (`buf_mode_i`=1).
- R6: In buffered mode, each cycle with a change on one or both triggers pushes exactly one entry. The entry's word is the `status_o` value after that edge, and its timestamp is the `ts_i` value sampled at that edge.
- R7: In raw mode no entry is ever pushed.
- R8: The queue is first-in first-out with its head shown on `ev_word_o` and `ev_ts_o` while `ev_valid_o` is 1. `ev_pop_i` removes the head, and a pop while the queue is empty is ignored.
- R9: An event that arrives while the queue holds `FIFO_DEPTH` entries is dropped, even if a pop happens in the same cycle, and the stored entries are left unchanged. The drop sets `ovf_o`, which stays set until a cycle with `clr_ovf_i` high and no drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 2 | Asynchronous trigger lines |
| ts_i | input | TS_W | Free-running frame time base |
| buf_mode_i | input | 1 | 1 = buffered mode, 0 = raw mode |
| clr_pend_i | input | 2 | Write-one-to-clear strobe for the pending bits |
| clr_ovf_i | input | 1 | Clears the overflow flag |
| ev_pop_i | input | 1 | Removes the queue head |
| status_o | output | 8 | Activity status word |
| ev_valid_o | output | 1 | Queue holds at least one entry |
| ev_word_o | output | 8 | Status word of the head entry |
| ev_ts_o | output | TS_W | Timestamp of the head entry |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The case that is hardest to reach from the ports is a new event arriving exactly when the queue is full, together with a set and a clear hitting the same pending bit in one cycle. A directed phase fills the queue with spaced toggles and no pops. It then forces one more event to see the drop, and after that drains the queue to check order and count. The random phase toggles triggers, pops, clears and mode often enough that these collisions come up again and again. Every output is compared each cycle with a bench model.

// File: rtl/trig_capture_pkg.sv
package trig_capture_pkg;
  localparam int unsigned NUM_TRIG = 2;
  localparam int unsigned WORD_W   = 8;
  localparam int unsigned PEND_LSB = 1;
  localparam int unsigned LVL_LSB  = 5;

  function automatic logic [WORD_W-1:0] pack_word(input logic [NUM_TRIG-1:0] lvl,
                                                  input logic [NUM_TRIG-1:0] pend);
    logic [WORD_W-1:0] w;
    w = '0;
    w[PEND_LSB +: NUM_TRIG] = pend;
    w[LVL_LSB  +: NUM_TRIG] = lvl;
    return w;
  endfunction
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/trig_event_det.sv
module trig_event_det #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_s_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] lvl_d_o,
  output logic [W-1:0] pend_d_o,
  output logic         event_o
);
  logic [W-1:0] lvl_q, pend_q, chg;

  assign chg      = lvl_s_i ^ lvl_q;
  assign pend_d_o = (pend_q & ~clr_i) | chg;  // set wins over clear
  assign lvl_d_o  = lvl_s_i;
  assign event_o  = |chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      pend_q <= '0;
    end else begin
      lvl_q  <= lvl_s_i;
      pend_q <= pend_d_o;
    end
  end

  assign lvl_o  = lvl_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/trig_fifo.sv
module trig_fifo #(
  parameter int unsigned DW    = 40,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic          valid_o,
  output logic [DW-1:0] rdata_o,
  output logic          drop_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, do_push, do_pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && (cnt_q != '0);
  assign drop_o  = push_i && full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= wdata_i;
        wr_q        <= nxt(wr_q);
      end
      if (do_pop) rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign valid_o = (cnt_q != '0);
  assign rdata_o = mem_q[rd_q];
endmodule

// File: rtl/trig_capture.sv
module trig_capture
  import trig_capture_pkg::*;
#(
  parameter int unsigned TS_W        = 32,
  parameter int unsigned FIFO_DEPTH  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic [TS_W-1:0]     ts_i,
  input  logic                buf_mode_i,
  input  logic [NUM_TRIG-1:0] clr_pend_i,
  input  logic                clr_ovf_i,
  input  logic                ev_pop_i,
  output logic [WORD_W-1:0]   status_o,
  output logic                ev_valid_o,
  output logic [WORD_W-1:0]   ev_word_o,
  output logic [TS_W-1:0]     ev_ts_o,
  output logic                ovf_o
);
  localparam int unsigned ENTRY_W = WORD_W + TS_W;

  logic [NUM_TRIG-1:0] lvl_s, lvl, pend, lvl_d, pend_d;
  logic                evt, drop, ovf_q;
  logic [ENTRY_W-1:0]  head;

  trig_sync #(.W(NUM_TRIG), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (trig_i),
    .q_o   (lvl_s)
  );

  trig_event_det #(.W(NUM_TRIG)) i_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_s_i (lvl_s),
    .clr_i   (clr_pend_i),
    .lvl_o   (lvl),
    .pend_o  (pend),
    .lvl_d_o (lvl_d),
    .pend_d_o(pend_d),
    .event_o (evt)
  );

  trig_fifo #(.DW(ENTRY_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (evt && buf_mode_i),
    .wdata_i({pack_word(lvl_d, pend_d), ts_i}),
    .pop_i  (ev_pop_i),
    .valid_o(ev_valid_o),
    .rdata_o(head),
    .drop_o (drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= (ovf_q && !clr_ovf_i) || drop;
  end

  assign status_o  = pack_word(lvl, pend);
  assign ev_word_o = head[ENTRY_W-1 -: WORD_W];
  assign ev_ts_o   = head[TS_W-1:0];
  assign ovf_o     = ovf_q;
endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       buf_mode_i,
  input logic [1:0] clr_pend_i,
  input logic       clr_ovf_i,
  input logic       ev_pop_i,
  input logic [7:0] status_o,
  input logic       ev_valid_o,
  input logic       ovf_o
);
  a_r2_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] == 1'b0) && (status_o[4:3] == 2'b00) && (status_o[7] == 1'b0));

  a_r4_pend0_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[1] && !clr_pend_i[0]) |=> status_o[1]);

  a_r4_pend1_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[2] && !clr_pend_i[1]) |=> status_o[2]);

  a_r5_change_sets_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[5] != $past(status_o[5])) |-> status_o[1]);

  a_r7_raw_no_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!buf_mode_i && !ev_valid_o) |=> !ev_valid_o);

  a_r8_hold_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_o && !ev_pop_i) |=> ev_valid_o);

  a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_ovf_i) |=> ovf_o);
endmodule

bind trig_capture trig_capture_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .buf_mode_i(buf_mode_i),
  .clr_pend_i(clr_pend_i),
  .clr_ovf_i (clr_ovf_i),
  .ev_pop_i  (ev_pop_i),
  .status_o  (status_o),
  .ev_valid_o(ev_valid_o),
  .ovf_o     (ovf_o)
);

// File: tb/test_trig_capture.sv
module test_trig_capture;
  logic        clk = 0, rst_n = 0;
  logic [1:0]  trig = 0, clr_pend = 0;
  logic        buf_mode = 0, clr_ovf = 0, pop = 0;
  logic [31:0] ts = 0;
  logic [7:0]  status, ev_word;
  logic [31:0] ev_ts;
  logic        ev_valid, ovf;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) ts <= ts + 1;

  trig_capture i_trig_capture (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .ts_i(ts), .buf_mode_i(buf_mode),
    .clr_pend_i(clr_pend), .clr_ovf_i(clr_ovf), .ev_pop_i(pop),
    .status_o(status), .ev_valid_o(ev_valid), .ev_word_o(ev_word), .ev_ts_o(ev_ts),
    .ovf_o(ovf));

  // bench model
  logic [1:0]  m_s1, m_s2, m_lv, m_pend;
  logic [7:0]  mq_w [4];
  logic [31:0] mq_t [4];
  int          mcnt;
  logic        m_ovf;

  function automatic logic [7:0] word(input logic [1:0] lv, input logic [1:0] pd);
    return {1'b0, lv, 2'b00, pd, 1'b0};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_lv = 0; m_pend = 0; mcnt = 0; m_ovf = 0;
    end else begin
      logic [1:0] chg;
      bit room, drop;
      chg    = m_s2 ^ m_lv;
      m_pend = (m_pend & ~clr_pend) | chg;
      m_lv   = m_s2;
      m_s2   = m_s1;
      m_s1   = trig;
      room   = mcnt < 4;
      drop   = 0;
      if (pop && mcnt > 0) begin
        for (int i = 0; i < 3; i++) begin mq_w[i] = mq_w[i+1]; mq_t[i] = mq_t[i+1]; end
        mcnt--;
      end
      if (buf_mode && chg != 0) begin
        if (room) begin mq_w[mcnt] = word(m_lv, m_pend); mq_t[mcnt] = ts; mcnt++; end
        else drop = 1;
      end
      m_ovf = (m_ovf && !clr_ovf) || drop;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R2 status", 64'(status), 64'(word(m_lv, m_pend)));
    chk("R8 valid", 64'(ev_valid), 64'(mcnt > 0));
    if (mcnt > 0) begin
      chk("R6 word", 64'(ev_word), 64'(mq_w[0]));
      chk("R6 ts", 64'(ev_ts), 64'(mq_t[0]));
    end
    chk("R9 ovf", 64'(ovf), 64'(m_ovf));
  endtask

  task automatic tick();
    @(negedge clk);
    cmp_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    chk("R1 status", 64'(status), 0);
    chk("R1 valid", 64'(ev_valid), 0);
    chk("R1 ovf", 64'(ovf), 0);
    // R3 latency, raw mode (R5, R7)
    trig = 2'b01;
    tick(); chk("R3 edge k", 64'(status), 0);
    tick(); chk("R3 edge k+1", 64'(status), 0);
    tick(); chk("R3 edge k+2", 64'(status), 64'h22);
    chk("R5 raw pending", 64'(status[1]), 1);
    chk("R7 raw no entry", 64'(ev_valid), 0);
    // R4 clear
    clr_pend = 2'b01; tick(); clr_pend = 0;
    chk("R4 cleared", 64'(status), 64'h20);
    // R6 buffered event with timestamp
    buf_mode = 1; v = ts; trig = 2'b11;
    repeat (3) tick();
    chk("R6 valid", 64'(ev_valid), 1);
    chk("R6 word", 64'(ev_word), 64'h64);
    chk("R6 ts", 64'(ev_ts), 64'(v + 2));
    // R9 fill and overflow
    for (int i = 0; i < 4; i++) begin trig[0] = ~trig[0]; tick(); tick(); end
    repeat (3) tick();
    chk("R9 ovf set", 64'(ovf), 1);
    chk("R9 head kept", 64'(ev_word), 64'h64);
    // R8 drain
    n = 0; pop = 1;
    while (ev_valid && n < 10) begin tick(); n++; end
    pop = 0;
    chk("R8 drain count", 64'(n), 4);
    tick(); chk("R8 empty pop ignored", 64'(ev_valid), 0);
    clr_ovf = 1; tick(); clr_ovf = 0;
    chk("R9 ovf cleared", 64'(ovf), 0);
    // random phase
    for (int c = 0; c < 4000; c++) begin
      for (int b = 0; b < 2; b++) if ($urandom_range(7) == 0) trig[b] = ~trig[b];
      clr_pend = {($urandom_range(9) == 0), ($urandom_range(9) == 0)};
      pop      = ($urandom_range(3) == 0);
      clr_ovf  = ($urandom_range(40) == 0);
      if ($urandom_range(150) == 0) buf_mode = ~buf_mode;
      tick();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule